// File: doc/BRIEF.md
# Amplifier Fault Supervisor Controller

This block sits between the protection comparators of a four-half-bridge class-D output stage and its gate-drive control. It takes already-digitized condition bits and produces two things. The first is a per-half-bridge set of controls: one puts the half-bridge in high impedance, the other turns off its high side. The second is a pair of active-low status flags, one for faults and one for the temperature warning. All condition inputs arrive asynchronously and pass through two-flop synchronizers. Every output is registered.

Faults fall into two classes. Thermal shutdown and overload shutdown latch: they stay in force until the control reset input goes low and then high again. Supply undervoltage, power-on-reset, oscillator loss and bootstrap undervoltage clear themselves once the condition goes away. An overload on one half-bridge silences a group of half-bridges, and the output-mode select decides which group. While the control reset is held low, every half-bridge is in high impedance and the fault flag is forced inactive.

Top module: `amp_fault_supervisor`

## Requirements
- R1: `warn_n_o` is low exactly when the synchronized warning comparator `temp_warn_i` is high. It is unaffected by the control reset and by faults, and on its own it never sets any bit of `hiz_o`.
- R2: When `temp_shut_i` is high while the control reset is high, all bits of `hiz_o` go to 1 and `fault_n_o` goes to 0. Both stay that way after the input drops, until `amp_rst_n_i` has been low and has risen again.
- R3: When any bit of `supply_uv_i` is high, or `por_i` is high, all bits of `hiz_o` are 1 and `fault_n_o` is 0. Both return to normal on their own once the inputs drop, with no reset needed.
- R4: While `amp_rst_n_i` is low, `fault_n_o` is 1 and all bits of `hiz_o` are 1, whatever conditions are present. Holding the control reset low clears every latched fault.
- R5: `boot_uv_i[i]` high sets only `hs_off_o[i]`. It does not touch `hiz_o` or `fault_n_o`, and it clears on its own.
- R6: `ovl_i[i]` (index 0 = half-bridge A, 1 = B, 2 = C, 3 = D) latches an overload for that half-bridge while the control reset is high. In bridge-tied mode (`mode_i` = 2'b00), an overload on A sets `hiz_o` = 4'b0011 and one on C sets 4'b1100. An overload on B or D sets only its own bit.
- R7: In parallel-bridge mode (`mode_i` = 2'b01), an overload on A sets all four `hiz_o` bits. An overload on B, C or D sets only its own bit.
- R8: In single-ended mode (`mode_i` = 2'b10), and for the spare code 2'b11, an overload sets only the `hiz_o` bit of its own half-bridge.
- R9: A latched overload holds `fault_n_o` at 0 and keeps its `hiz_o` group set after the request drops, until the control reset is toggled low then high.
- R10: `osc_lost_i` high sets all bits of `hiz_o` without lowering `fault_n_o`, and the outputs recover on their own once it drops.
- R11: An input change reaches the outputs on the third rising clock edge after it is first sampled: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| amp_rst_n_i | input | 1 | Active-low control reset of the amplifier (asynchronous) |
| supply_uv_i | input | NUM_SUP | Undervoltage comparator per monitored supply |
| por_i | input | 1 | Power-on-reset active |
| temp_warn_i | input | 1 | Junction above warning temperature |
| temp_shut_i | input | 1 | Junction above shutdown temperature |
| boot_uv_i | input | NUM_HB | Bootstrap undervoltage per half-bridge |
| ovl_i | input | NUM_HB | Overload shutdown request per half-bridge |
| osc_lost_i | input | 1 | No oscillator activity while following an external clock |
| mode_i | input | 2 | Output mode: 00 bridge-tied, 01 parallel-bridge, 10/11 single-ended |
| hiz_o | output | NUM_HB | 1 puts the half-bridge in high impedance |
| hs_off_o | output | NUM_HB | 1 turns off the half-bridge high side |
| fault_n_o | output | 1 | Active-low fault flag |
| warn_n_o | output | 1 | Active-low temperature warning flag |

## Verification
A latch that fails to set, or that clears while the control reset stays high, shows up as `hiz_o` and `fault_n_o` going back to normal as soon as the overload or shutdown input drops. That is three edges after the drop. A latch that sets wrongly or fails to clear on a reset toggle shows up as a stuck `fault_n_o` on the first cycle after reset rises. A wrong group mapping shows up in the same cycle as the fault flag, as a wrong `hiz_o` pattern. The bench runs a reference model against the outputs every cycle, so a wrong pattern is reported on the cycle it first appears.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef enum logic [1:0] {
    MODE_BRIDGE   = 2'b00,
    MODE_PARALLEL = 2'b01,
    MODE_SINGLE   = 2'b10,
    MODE_SPARE    = 2'b11
  } out_mode_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import fsup_pkg::*;

  logic [WIDTH-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/fsup_group_map.sv
module fsup_group_map #(
  parameter int unsigned NUM_HB = 4
) (
  input  logic [1:0]        mode_i,
  input  logic [NUM_HB-1:0] err_i,
  output logic [NUM_HB-1:0] shut_o
);
  import fsup_pkg::*;

  logic is_bridge;
  logic is_parallel;

  assign is_bridge   = (mode_i == MODE_BRIDGE);
  assign is_parallel = (mode_i == MODE_PARALLEL);

  for (genvar j = 0; j < NUM_HB; j++) begin : g_hb
    logic from_pair;
    if (j % 2 == 1) begin : g_odd
      assign from_pair = is_bridge & err_i[j-1];
    end else begin : g_even
      assign from_pair = 1'b0;
    end
    assign shut_o[j] = err_i[j] | from_pair | (is_parallel & err_i[0]);
  end

endmodule

// File: rtl/fsup_latch_bank.sv
module fsup_latch_bank #(
  parameter int unsigned NUM_HB = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              run_i,
  input  logic              shut_set_i,
  input  logic [NUM_HB-1:0] ovl_set_i,
  output logic              ote_nxt_o,
  output logic [NUM_HB-1:0] ovl_nxt_o,
  output logic              ote_q_o,
  output logic [NUM_HB-1:0] ovl_q_o
);

  logic              ote_d;
  logic [NUM_HB-1:0] ovl_d;

  always_comb begin
    if (!run_i) begin
      ote_d = 1'b0;
      ovl_d = '0;
    end else begin
      ote_d = ote_q_o | shut_set_i;
      ovl_d = ovl_q_o | ovl_set_i;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ote_q_o <= 1'b0;
      ovl_q_o <= '0;
    end else begin
      ote_q_o <= ote_d;
      ovl_q_o <= ovl_d;
    end
  end

  assign ote_nxt_o = ote_d;
  assign ovl_nxt_o = ovl_d;

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int unsigned NUM_HB  = 4,
  parameter int unsigned NUM_SUP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               amp_rst_n_i,
  input  logic [NUM_SUP-1:0] supply_uv_i,
  input  logic               por_i,
  input  logic               temp_warn_i,
  input  logic               temp_shut_i,
  input  logic [NUM_HB-1:0]  boot_uv_i,
  input  logic [NUM_HB-1:0]  ovl_i,
  input  logic               osc_lost_i,
  input  logic [1:0]         mode_i,
  output logic [NUM_HB-1:0]  hiz_o,
  output logic [NUM_HB-1:0]  hs_off_o,
  output logic               fault_n_o,
  output logic               warn_n_o
);

  localparam int unsigned COND_W = NUM_SUP + 5 + 2 * NUM_HB + 2;

  // block reset: asserted asynchronously, released through two flops
  logic rst_sync_n;
  fsup_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .arst_n(rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  // condition synchronizers
  logic [COND_W-1:0] cond_raw;
  logic [COND_W-1:0] cond_s;

  assign cond_raw = {amp_rst_n_i, supply_uv_i, por_i, temp_warn_i, temp_shut_i,
                     osc_lost_i, boot_uv_i, ovl_i, mode_i};

  fsup_sync #(.WIDTH(COND_W), .RST_VAL(1'b0)) u_cond_sync (
    .clk   (clk),
    .arst_n(rst_sync_n),
    .d_i   (cond_raw),
    .q_o   (cond_s)
  );

  logic               run_s;
  logic [NUM_SUP-1:0] uv_s;
  logic               por_s;
  logic               warn_s;
  logic               shut_s;
  logic               osc_s;
  logic [NUM_HB-1:0]  boot_s;
  logic [NUM_HB-1:0]  ovl_s;
  logic [1:0]         mode_s;

  assign {run_s, uv_s, por_s, warn_s, shut_s, osc_s, boot_s, ovl_s, mode_s} = cond_s;

  // latching faults
  logic              ote_nxt;
  logic [NUM_HB-1:0] ovl_nxt;
  logic              ote_lat_q;
  logic [NUM_HB-1:0] ovl_lat_q;

  fsup_latch_bank #(.NUM_HB(NUM_HB)) u_latch (
    .clk       (clk),
    .arst_n    (rst_sync_n),
    .run_i     (run_s),
    .shut_set_i(shut_s),
    .ovl_set_i (ovl_s),
    .ote_nxt_o (ote_nxt),
    .ovl_nxt_o (ovl_nxt),
    .ote_q_o   (ote_lat_q),
    .ovl_q_o   (ovl_lat_q)
  );

  // overload group mapping by output mode
  logic [NUM_HB-1:0] grp_shut;
  fsup_group_map #(.NUM_HB(NUM_HB)) u_map (
    .mode_i(mode_s),
    .err_i (ovl_nxt),
    .shut_o(grp_shut)
  );

  // output next state
  logic              supply_bad;
  logic              global_off;
  logic [NUM_HB-1:0] hiz_d;
  logic [NUM_HB-1:0] hs_off_d;
  logic              fault_n_d;
  logic              warn_n_d;

  always_comb begin
    supply_bad = (|uv_s) | por_s;
    global_off = !run_s | supply_bad | ote_nxt | osc_s;
    hiz_d      = global_off ? {NUM_HB{1'b1}} : grp_shut;
    hs_off_d   = boot_s;
    fault_n_d  = !run_s | !(supply_bad | ote_nxt | (|ovl_nxt));
    warn_n_d   = !warn_s;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hiz_o     <= {NUM_HB{1'b1}};
      hs_off_o  <= '0;
      fault_n_o <= 1'b1;
      warn_n_o  <= 1'b1;
    end else begin
      hiz_o     <= hiz_d;
      hs_off_o  <= hs_off_d;
      fault_n_o <= fault_n_d;
      warn_n_o  <= warn_n_d;
    end
  end

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int unsigned NUM_HB  = 4,
  parameter int unsigned NUM_SUP = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_s,
  input logic [NUM_SUP-1:0] uv_s,
  input logic               por_s,
  input logic               ote_lat_q,
  input logic [NUM_HB-1:0]  ovl_lat_q,
  input logic [NUM_HB-1:0]  hiz_o,
  input logic               fault_n_o
);

  // R2: a latched thermal shutdown always shows as all Hi-Z with the flag low
  a_r2_ote_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    ote_lat_q |-> ((&hiz_o) && !fault_n_o));

  // R3: supply undervoltage or power-on-reset forces all Hi-Z one edge later
  a_r3_supply_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|uv_s) || $past(por_s)) |-> (&hiz_o));

  // R4: control reset low forces the fault flag inactive
  a_r4_flag_released: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_s) |-> fault_n_o);

  // R4: control reset low forces all half-bridges to Hi-Z
  a_r4_reset_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_s) |-> (&hiz_o));

  // R9: any latched overload keeps the fault flag low
  a_r9_ovl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovl_lat_q) |-> !fault_n_o);

  // R2/R9: latched faults exist only while the control reset is high
  a_r2_latch_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ote_lat_q || (|ovl_lat_q)) |-> $past(run_s));

endmodule

bind amp_fault_supervisor fsup_checker #(.NUM_HB(NUM_HB), .NUM_SUP(NUM_SUP)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .run_s    (run_s),
  .uv_s     (uv_s),
  .por_s    (por_s),
  .ote_lat_q(ote_lat_q),
  .ovl_lat_q(ovl_lat_q),
  .hiz_o    (hiz_o),
  .fault_n_o(fault_n_o)
);

// File: tb/amp_fault_supervisor_tb_top.sv
module amp_fault_supervisor_tb_top;

  localparam int NHB  = 4;
  localparam int NSUP = 3;

  logic            clk;
  logic            rst_n;
  logic            amp_rst_n;
  logic [NSUP-1:0] uv;
  logic            por;
  logic            warn;
  logic            shut;
  logic [NHB-1:0]  boot;
  logic [NHB-1:0]  ovl;
  logic            osc;
  logic [1:0]      mode;
  logic [NHB-1:0]  hiz;
  logic [NHB-1:0]  hs_off;
  logic            fault_n;
  logic            warn_n;

  amp_fault_supervisor #(.NUM_HB(NHB), .NUM_SUP(NSUP)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .amp_rst_n_i(amp_rst_n),
    .supply_uv_i(uv),
    .por_i      (por),
    .temp_warn_i(warn),
    .temp_shut_i(shut),
    .boot_uv_i  (boot),
    .ovl_i      (ovl),
    .osc_lost_i (osc),
    .mode_i     (mode),
    .hiz_o      (hiz),
    .hs_off_o   (hs_off),
    .fault_n_o  (fault_n),
    .warn_n_o   (warn_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic            rn;
    logic [NSUP-1:0] uv;
    logic            por;
    logic            warn;
    logic            shut;
    logic [NHB-1:0]  boot;
    logic [NHB-1:0]  ovl;
    logic            osc;
    logic [1:0]      mode;
  } stim_t;

  stim_t          hist[$];
  bit             m_ote;
  bit [NHB-1:0]   m_ovl;
  bit [NHB-1:0]   e_hiz;
  bit [NHB-1:0]   e_hs;
  bit             e_fault_n;
  bit             e_warn_n;
  int             errs;
  int             checks;
  string          cur_req;
  bit             done;

  // reference model: outputs after edge E reflect inputs sampled at edge E-2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
      m_ote = 0; m_ovl = '0;
      e_hiz = '1; e_hs = '0; e_fault_n = 1; e_warn_n = 1;
    end else begin
      stim_t cur;
      stim_t d;
      bit [NHB-1:0] grp;
      bit gl;
      cur = '{amp_rst_n, uv, por, warn, shut, boot, ovl, osc, mode};
      hist.push_back(cur);
      d = hist.pop_front();
      if (!d.rn) begin
        m_ote = 0; m_ovl = '0;
      end else begin
        m_ote = m_ote | d.shut;
        m_ovl = m_ovl | d.ovl;
      end
      grp = '0;
      for (int i = 0; i < NHB; i++) begin
        if (m_ovl[i]) begin
          case (d.mode)
            2'b00: begin grp[i] = 1; if (i % 2 == 0) grp[i+1] = 1; end
            2'b01: begin if (i == 0) grp = '1; else grp[i] = 1; end
            default: grp[i] = 1;
          endcase
        end
      end
      gl = !d.rn || (d.uv != 0) || d.por || m_ote || d.osc;
      e_hiz     = gl ? '1 : grp;
      e_hs      = d.boot;
      e_fault_n = !d.rn || !((d.uv != 0) || d.por || m_ote || (m_ovl != 0));
      e_warn_n  = !d.warn;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (hiz !== e_hiz || fault_n !== e_fault_n) begin
        errs++;
        $display("FAIL %s model: hiz=%b fault_n=%b expected hiz=%b fault_n=%b",
                 cur_req, hiz, fault_n, e_hiz, e_fault_n);
      end
      checks++;
      if (warn_n !== e_warn_n) begin
        errs++;
        $display("FAIL R1 model: warn_n=%b expected %b", warn_n, e_warn_n);
      end
      checks++;
      if (hs_off !== e_hs) begin
        errs++;
        $display("FAIL R5 model: hs_off=%b expected %b", hs_off, e_hs);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [NHB-1:0] h,
                            input logic f, input logic w, input logic [NHB-1:0] hs);
    checks++;
    if (hiz !== h || fault_n !== f || warn_n !== w || hs_off !== hs) begin
      errs++;
      $display("FAIL %s: hiz=%b fault_n=%b warn_n=%b hs_off=%b expected %b %b %b %b",
               req, hiz, fault_n, warn_n, hs_off, h, f, w, hs);
    end
  endtask

  task automatic toggle_reset();
    amp_rst_n = 0; tick(4);
    amp_rst_n = 1; tick(4);
  endtask

  task automatic pulse_ovl(input int idx);
    ovl[idx] = 1; tick(1);
    ovl[idx] = 0; tick(5);
  endtask

  // watchdog
  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    errs = 0; checks = 0; done = 0; cur_req = "R4";
    rst_n = 0; amp_rst_n = 0; uv = '0; por = 0; warn = 0; shut = 0;
    boot = '0; ovl = '0; osc = 0; mode = 2'b00;
    tick(3);
    rst_n = 1;
    tick(6);
    // R4: reset state, control reset low
    expect_out("R4 reset state", 4'b1111, 1'b1, 1'b1, 4'b0000);

    amp_rst_n = 1; tick(2);
    // R11: two edges after sampling the old state still shows
    expect_out("R11 latency early", 4'b1111, 1'b1, 1'b1, 4'b0000);
    tick(1);
    expect_out("R11 latency edge3", 4'b0000, 1'b1, 1'b1, 4'b0000);
    tick(3);

    // R1: warning only moves the warning flag
    cur_req = "R1";
    warn = 1; tick(4);
    expect_out("R1 warn set", 4'b0000, 1'b1, 1'b0, 4'b0000);
    warn = 0; tick(4);
    expect_out("R1 warn clear", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R5: bootstrap undervoltage on C
    cur_req = "R5";
    boot[2] = 1; tick(4);
    expect_out("R5 boot C", 4'b0000, 1'b1, 1'b1, 4'b0100);
    boot[2] = 0; tick(4);
    expect_out("R5 boot clear", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R3: supply undervoltage and power-on-reset self-clear
    cur_req = "R3";
    uv[1] = 1; tick(4);
    expect_out("R3 uv", 4'b1111, 1'b0, 1'b1, 4'b0000);
    uv[1] = 0; tick(4);
    expect_out("R3 uv clear", 4'b0000, 1'b1, 1'b1, 4'b0000);
    por = 1; tick(4);
    expect_out("R3 por", 4'b1111, 1'b0, 1'b1, 4'b0000);
    por = 0; tick(4);
    expect_out("R3 por clear", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R10: oscillator loss, no flag
    cur_req = "R10";
    osc = 1; tick(4);
    expect_out("R10 osc", 4'b1111, 1'b1, 1'b1, 4'b0000);
    osc = 0; tick(4);
    expect_out("R10 osc clear", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R6: bridge-tied grouping
    cur_req = "R6";
    pulse_ovl(0);
    expect_out("R6 btl A", 4'b0011, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    expect_out("R6 cleared", 4'b0000, 1'b1, 1'b1, 4'b0000);
    pulse_ovl(2);
    expect_out("R6 btl C", 4'b1100, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    pulse_ovl(1);
    expect_out("R6 btl B", 4'b0010, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    pulse_ovl(3);
    expect_out("R6 btl D", 4'b1000, 1'b0, 1'b1, 4'b0000);
    toggle_reset();

    // R7: parallel-bridge grouping
    cur_req = "R7";
    mode = 2'b01; tick(4);
    pulse_ovl(0);
    expect_out("R7 pbtl A", 4'b1111, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    pulse_ovl(2);
    expect_out("R7 pbtl C", 4'b0100, 1'b0, 1'b1, 4'b0000);
    toggle_reset();

    // R8: single-ended and spare code
    cur_req = "R8";
    mode = 2'b10; tick(4);
    pulse_ovl(0);
    expect_out("R8 se A", 4'b0001, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    mode = 2'b11; tick(4);
    pulse_ovl(1);
    expect_out("R8 spare B", 4'b0010, 1'b0, 1'b1, 4'b0000);

    // R9: latch holds for a long time, then clears on toggle
    cur_req = "R9";
    tick(40);
    expect_out("R9 hold", 4'b0010, 1'b0, 1'b1, 4'b0000);
    toggle_reset();
    expect_out("R9 cleared", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R2: thermal shutdown latches
    cur_req = "R2";
    mode = 2'b00;
    shut = 1; tick(2);
    shut = 0; tick(30);
    expect_out("R2 latched", 4'b1111, 1'b0, 1'b1, 4'b0000);
    amp_rst_n = 0; tick(4);
    // R4: flag released while reset low, even with shutdown active
    cur_req = "R4";
    shut = 1; uv[0] = 1; tick(4);
    expect_out("R4 flag forced high", 4'b1111, 1'b1, 1'b1, 4'b0000);
    shut = 0; uv[0] = 0; tick(4);
    cur_req = "R2";
    amp_rst_n = 1; tick(4);
    expect_out("R2 cleared", 4'b0000, 1'b1, 1'b1, 4'b0000);

    // R1: warning stays visible during control reset
    cur_req = "R1";
    amp_rst_n = 0; warn = 1; tick(4);
    expect_out("R1 warn in reset", 4'b1111, 1'b1, 1'b0, 4'b0000);
    warn = 0; amp_rst_n = 1; tick(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule